// File: doc/BRIEF.md
# Programmable Reload Counter with Stretched Output

This block is the programmable stage of a dual-modulus frequency divider. It runs on the prescaler's output clock. A 6-bit counter steps upward from a preset value, one step per clock. When it reaches the value 62, a registered reload strobe follows on the next clock, and the edge after that writes the preset back into the counter. Because the detect and the strobe each add one cycle, one output period lasts 64 minus the preset.

The divided output is high while the 62 detect is true and also while the reload strobe is high. The output pulse is therefore two clocks wide, not one. The preset is sampled only at the reload edge. Software or a fractional sequencer can therefore apply a new ratio on every output period. The strobe is also brought out so that a small companion counter can reload at the same instant.

A synchronous reset holds the counter at the preset and clears the strobe. Several of these dividers released by the same reset therefore start in step.

Top module: `reload_div`

## Requirements
- R1: Outside reset and outside a reload edge, the counter advances by exactly one on every clock and wraps from 63 to 0.
- R2: The divided output `div_out` is high in every cycle in which the counter holds the value 62.
- R3: `load_strobe` is high for exactly one cycle, namely the cycle immediately after the counter held 62. In every other cycle it is low.
- R4: On the clock edge that ends a strobe cycle, the counter takes the value on `preset` at that edge.
- R5: With a steady preset D in 0..62, the output repeats every 64 − D clocks. With D = 63 the counter wraps once before reaching 62, so the period is 65 clocks.
- R6: `div_out` equals the 62 detect ORed with the strobe. It is therefore high for exactly two consecutive clocks per period when D ≠ 62, and continuously high when D = 62.
- R7: While `rst` is high, on each clock the counter is set to `preset` and the strobe is cleared. The first edge with `rst` low advances the counter from D, so `div_out` first goes high 62 − D cycles after release.
- R8: A change on `preset` between two reloads has no effect on the period already running. The new value only governs the period that starts at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| preset | input | 6 | Reload value D; the ratio is 64 − D |
| load_strobe | output | 1 | One-cycle reload strobe for a companion counter |
| div_out | output | 1 | Divided output, two clocks wide |

## Verification
The bench measures the period and the pulse width for presets 0, 10, 40, 61 and 63. Two kinds of fault show up here: a design that detects at overflow rather than at 62, or that loads on the detect cycle, is off by one or two cycles in the period. The bench also holds the preset at 62 and expects the output to stay high throughout; a design that derives the output from the strobe alone would pulse every other cycle instead.

The bench changes the preset in the middle of a running period. A design that loads the preset continuously, and does not sample it at the reload edge, would shorten that period.

Finally, the bench counts the cycles from reset release to the first output pulse. A reset that cleared the counter to zero rather than loading the preset would show up as a wrong count.

// File: rtl/reload_div_pkg.sv
package reload_div_pkg;

    // Default counter width for the programmable stage.
    localparam int DEF_CNT_W = 6;

    // Terminal value detected by the counter: two below full scale, so
    // that detect plus registered reload add up to a full 2**W cycle.
    function automatic int term_value(input int width);
        return (1 << width) - 2;
    endfunction

endpackage

// File: rtl/reload_tc_detect.sv
module reload_tc_detect #(
    parameter int W  = 6,
    parameter int TC = 62
) (
    input  logic [W-1:0] value,
    output logic         hit
);
    localparam logic [W-1:0] TC_V = TC[W-1:0];

    logic [W-1:0] bit_match;

    // One equality term per bit, then a W-input AND.
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            if (TC_V[gi]) begin : g_one
                assign bit_match[gi] = value[gi];
            end else begin : g_zero
                assign bit_match[gi] = ~value[gi];
            end
        end
    endgenerate

    assign hit = &bit_match;

endmodule

// File: rtl/reload_tcount.sv
module reload_tcount #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [W-1:0] tgl_en;

    // Toggle-flop carry chain: bit i flips when all lower bits are one.
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_tgl
            if (gi == 0) begin : g_lsb
                assign tgl_en[gi] = 1'b1;
            end else begin : g_upper
                assign tgl_en[gi] = tgl_en[gi-1] & st_q.cnt[gi-1];
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rst || load) begin
            st_d.cnt = load_val;
        end else begin
            st_d.cnt = st_q.cnt ^ tgl_en;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.cnt;

    // R1: plain counting step is +1 modulo 2**W
    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        !load |=> q == W'($past(q) + 1'b1));

    // R4: reload takes the value presented at the reload edge
    a_r4_reload_value: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(load_val));

endmodule

// File: rtl/reload_div.sv
module reload_div #(
    parameter int CNT_W = reload_div_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] preset,
    output logic             load_strobe,
    output logic             div_out
);
    localparam int TERM = reload_div_pkg::term_value(CNT_W);

    typedef struct packed {
        logic load;
    } ctl_state_t;

    ctl_state_t       ctl_d, ctl_q;
    logic [CNT_W-1:0] count;
    logic             tc_hit;

    reload_tcount #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl_q.load),
        .load_val (preset),
        .q        (count)
    );

    reload_tc_detect #(.W(CNT_W), .TC(TERM)) u_detect (
        .value (count),
        .hit   (tc_hit)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (rst) begin
            ctl_d.load = 1'b0;
        end else begin
            ctl_d.load = tc_hit;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign load_strobe = ctl_q.load;
    assign div_out     = tc_hit | ctl_q.load;

    // R3: strobe follows the terminal detect by one cycle
    a_r3_strobe_after_hit: assert property (@(posedge clk) disable iff (rst)
        tc_hit |=> load_strobe);

    // R3: strobe never lasts two cycles
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
        load_strobe |=> !load_strobe);

    // R6: output pulse is at least two clocks wide
    a_r6_pulse_two: assert property (@(posedge clk) disable iff (rst)
        $rose(div_out) |=> div_out);

    // R7: reset clears the strobe
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> !load_strobe);

endmodule

// File: tb/sim_reload_div.sv
module sim_reload_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] preset = 6'd20;
    logic       load_strobe;
    logic       div_out;

    int applied = 0;
    int miscompares = 0;

    // behavioural reference state
    int m_cnt = 0;
    bit m_load = 1'b0;
    bit armed = 1'b0;

    always #10 clk = ~clk;

    reload_div u0 (
        .clk         (clk),
        .rst         (rst),
        .preset      (preset),
        .load_strobe (load_strobe),
        .div_out     (div_out)
    );

    always @(posedge clk) begin
        int nc;
        bit nl;
        if (rst) begin
            nc = int'(preset);
            nl = 1'b0;
        end else begin
            nl = (m_cnt == 62);
            nc = m_load ? int'(preset) : (m_cnt + 1) % 64;
        end
        m_cnt  <= nc;
        m_load <= nl;
        armed  <= 1'b1;
    end

    function automatic bit m_out();
        return (m_cnt == 62) || m_load;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        applied++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock; compare against the model at the falling edge
    task automatic cyc();
        @(negedge clk);
        if (armed) begin
            chk(load_strobe === m_load, "R3 strobe vs model", int'(load_strobe), int'(m_load));
            chk(div_out === m_out(), "R6 div_out vs model (R2)", int'(div_out), int'(m_out()));
        end
    endtask

    task automatic wait_rise();
        bit prev;
        int guard = 0;
        do begin
            prev = div_out;
            cyc();
            guard++;
        end while (!(!prev && div_out) && guard < 400);
    endtask

    task automatic measure(input int d, input int exp_per, input int exp_hi);
        int n = 0;
        int hi = 1;
        int st = 0;
        bit prev;
        preset = 6'(d);
        wait_rise();
        wait_rise();
        do begin
            prev = div_out;
            cyc();
            n++;
            if (load_strobe) st++;
            if (div_out && !(!prev && div_out)) hi++;
        end while (!(!prev && div_out) && n < 400);
        chk(n == exp_per, $sformatf("R5 period D=%0d (R1 counting)", d), n, exp_per);
        chk(hi == exp_hi, $sformatf("R6 pulse width D=%0d", d), hi, exp_hi);
        chk(st == 1, $sformatf("R3 strobes per period D=%0d", d), st, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        int n;
        int hi;
        // R7: reset state
        repeat (3) @(negedge clk);
        chk(load_strobe === 1'b0, "R7 strobe low in reset", int'(load_strobe), 0);
        chk(div_out === 1'b0, "R7 div_out low in reset (D=20)", int'(div_out), 0);
        rst = 1'b0;
        n = 0;
        do begin
            cyc();
            n++;
        end while (!div_out && n < 200);
        chk(n == 42, "R7 first pulse after release", n, 42);

        measure(20, 44, 2);
        measure(0, 64, 2);
        measure(10, 54, 2);
        measure(40, 24, 2);
        measure(61, 3, 2);
        measure(63, 65, 2);

        // R8: mid-period preset change only affects the next period
        preset = 6'd30;
        wait_rise();
        wait_rise();
        cyc();
        cyc();
        preset = 6'd5;
        n = 2;
        begin
            bit prev;
            do begin
                prev = div_out;
                cyc();
                n++;
            end while (!(!prev && div_out) && n < 400);
        end
        chk(n == 34, "R8 running period keeps old preset", n, 34);
        n = 0;
        begin
            bit prev;
            do begin
                prev = div_out;
                cyc();
                n++;
            end while (!(!prev && div_out) && n < 400);
        end
        chk(n == 59, "R8 next period uses new preset (R4)", n, 59);

        // R6: D = 62 keeps the output high
        preset = 6'd62;
        repeat (80) cyc();
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            cyc();
            if (div_out) hi++;
        end
        chk(hi == 10, "R6 constant high at D=62", hi, 10);

        // R7: reset mid-run then restart with D=50
        preset = 6'd50;
        rst = 1'b1;
        repeat (2) cyc();
        chk(load_strobe === 1'b0, "R7 strobe cleared by reset", int'(load_strobe), 0);
        rst = 1'b0;
        n = 0;
        do begin
            cyc();
            n++;
        end while (!div_out && n < 200);
        chk(n == 12, "R7 restart aligns to preset", n, 12);
        repeat (20) cyc();

        $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule